// File: doc/BRIEF.md
# Chained Multiply-Accumulate Pipeline

This block is a three-register multiply-accumulate datapath for signed integer operands. Each issue slot carries one multiply and one add. The multiplier works on the newest operand pair. The adder folds the product that was formed one slot earlier into its own registered sum. That sum is shown on the result port at all times, and the same register feeds back into the adder. A caller streams the element pairs of two vectors into the block. It tags the first pair of each vector so the running sum restarts from zero. When the stream ends, the caller uses the drain input to push the last products through to the accumulator.

The pipeline moves forward only in slots that carry something: a real operand pair, or a drain slot of zero operands. An empty slot freezes every stage. Results therefore come out only as fast as pairs go in, and keeping the pipe full gives one accumulated product per clock. A valid flag travels with each stage. The output-valid flag pulses exactly when a real product has just been folded into the sum.

Top module: `mac_chain_pipe`

## Requirements
- R1: While reset is high, and in the first cycle after it, `result` is zero and `out_valid` is low.
- R2: With `in_valid` high on every cycle, a new pair is accepted each cycle. After the first two cycles, `out_valid` stays high on every cycle.
- R3: A pair accepted on clock edge k is folded into `result` on edge k+2, provided edges k+1 and k+2 both advance the pipe.
- R4: Each valid pair adds `in_a*in_b` to the running sum, and the sum is the signed total of all products since the last restart.
- R5: A pair presented with `in_clear` high restarts the sum: after it lands, `result` equals that pair's product alone.
- R6: A cycle with `in_valid` and `drain` both low is a bubble. No stage moves, `out_valid` is low on the following cycle, and `result` does not change.
- R7: A cycle with `drain` high and `in_valid` low advances the pipe with a zero, non-valid slot. Two such cycles bring every product in flight to `result`. Drain slots by themselves never change `result` or raise `out_valid`.
- R8: When `in_valid` and `drain` are both high, the operand pair is accepted and the drain request is ignored for that cycle.
- R9: The sum is kept modulo 2^ACC_W in two's complement and wraps silently on overflow.
- R10: `out_valid` is high on exactly the cycles after an edge that folded a real product into `result`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair on `in_a`/`in_b` is real this cycle |
| in_clear | input | 1 | This pair starts a new sum (used only with `in_valid`) |
| in_a | input | A_W | Signed multiplicand |
| in_b | input | B_W | Signed multiplier |
| drain | input | 1 | Push a zero slot to advance the pipe with no new data |
| result | output | ACC_W | Registered running sum, also the adder's feedback value |
| out_valid | output | 1 | `result` has just absorbed a real product |

## Verification
The bench builds the block with 8-bit operands and a 20-bit accumulator. At these sizes a run of 32 products of (-128)·(-128) reaches exactly 2^19, so the wrap of the signed sum is hit after a short, known sequence. The same narrow operands make the extreme mixed-sign product and the zero-padded random vectors cheap to cover exhaustively by hand-computed dot products. The 16-bit product against a 20-bit sum also exercises the sign-extension branch of the accumulator.

// File: rtl/mac_chain_pkg.sv
`timescale 1ns/1ps
package mac_chain_pkg;

    localparam int unsigned DEF_A_W   = 16;
    localparam int unsigned DEF_B_W   = 16;
    localparam int unsigned DEF_ACC_W = 40;

    // What a single issue slot carries into the first pipeline register
    typedef enum logic [1:0] {
        SLOT_BUBBLE = 2'd0,
        SLOT_DATA   = 2'd1,
        SLOT_FLUSH  = 2'd2
    } slot_kind_e;

    // Real data wins over a flush request; nothing at all is a bubble
    function automatic slot_kind_e classify_slot(input logic has_data, input logic wants_flush);
        if (has_data)
            return SLOT_DATA;
        else if (wants_flush)
            return SLOT_FLUSH;
        else
            return SLOT_BUBBLE;
    endfunction

    function automatic logic slot_moves(input slot_kind_e kind);
        return kind != SLOT_BUBBLE;
    endfunction

endpackage

// File: rtl/mac_issue_stage.sv
`timescale 1ns/1ps
module mac_issue_stage
    import mac_chain_pkg::*;
#(
    parameter int unsigned A_W = DEF_A_W,
    parameter int unsigned B_W = DEF_B_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic                  in_clear,
    input  logic signed [A_W-1:0] in_a,
    input  logic signed [B_W-1:0] in_b,
    input  logic                  drain,
    output logic                  adv,
    output logic                  s1_valid,
    output logic                  s1_clr,
    output logic signed [A_W-1:0] s1_a,
    output logic signed [B_W-1:0] s1_b
);

    typedef struct packed {
        logic                  valid;
        logic                  clr;
        logic signed [A_W-1:0] a;
        logic signed [B_W-1:0] b;
    } opnd_slot_t;

    slot_kind_e kind;
    opnd_slot_t slot_n;
    opnd_slot_t slot_q;

    always_comb begin
        kind   = classify_slot(in_valid, drain);
        adv    = slot_moves(kind);
        slot_n = '0;
        if (kind == SLOT_DATA) begin
            slot_n.valid = 1'b1;
            slot_n.clr   = in_clear;
            slot_n.a     = in_a;
            slot_n.b     = in_b;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            slot_q <= '0;
        else if (adv)
            slot_q <= slot_n;
    end

    assign s1_valid = slot_q.valid;
    assign s1_clr   = slot_q.clr;
    assign s1_a     = slot_q.a;
    assign s1_b     = slot_q.b;

    // R7
    drain_zero_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (drain && !in_valid) |=> (!s1_valid && s1_a == '0 && s1_b == '0));

    // R8
    data_over_drain_chk: assert property (@(posedge clk) disable iff (rst)
        (drain && in_valid) |=> (s1_valid && s1_a == $past(in_a) && s1_b == $past(in_b)));

    // R6
    bubble_freeze_s1_chk: assert property (@(posedge clk) disable iff (rst)
        (!drain && !in_valid) |=> ($stable(s1_valid) && $stable(s1_a) && $stable(s1_b)));

endmodule

// File: rtl/mac_mult_stage.sv
`timescale 1ns/1ps
module mac_mult_stage
    import mac_chain_pkg::*;
#(
    parameter int unsigned A_W = DEF_A_W,
    parameter int unsigned B_W = DEF_B_W,
    localparam int unsigned P_W = A_W + B_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  adv,
    input  logic                  s1_valid,
    input  logic                  s1_clr,
    input  logic signed [A_W-1:0] s1_a,
    input  logic signed [B_W-1:0] s1_b,
    output logic                  s2_valid,
    output logic                  s2_clr,
    output logic signed [P_W-1:0] s2_prod
);

    typedef struct packed {
        logic                  valid;
        logic                  clr;
        logic signed [P_W-1:0] prod;
    } prod_slot_t;

    logic signed [P_W-1:0] a_wide;
    logic signed [P_W-1:0] b_wide;
    prod_slot_t            prod_n;
    prod_slot_t            prod_q;

    always_comb begin
        a_wide       = P_W'(s1_a);
        b_wide       = P_W'(s1_b);
        prod_n.valid = s1_valid;
        prod_n.clr   = s1_clr;
        prod_n.prod  = a_wide * b_wide;
    end

    always_ff @(posedge clk) begin
        if (rst)
            prod_q <= '0;
        else if (adv)
            prod_q <= prod_n;
    end

    assign s2_valid = prod_q.valid;
    assign s2_clr   = prod_q.clr;
    assign s2_prod  = prod_q.prod;

    // R4
    product_follows_operands_chk: assert property (@(posedge clk) disable iff (rst)
        adv |=> (s2_prod == P_W'($past(s1_a)) * P_W'($past(s1_b))));

    // R3
    valid_moves_one_stage_chk: assert property (@(posedge clk) disable iff (rst)
        adv |=> (s2_valid == $past(s1_valid)));

endmodule

// File: rtl/mac_accum_stage.sv
`timescale 1ns/1ps
module mac_accum_stage
    import mac_chain_pkg::*;
#(
    parameter int unsigned P_W   = 2 * DEF_A_W,
    parameter int unsigned ACC_W = DEF_ACC_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    adv,
    input  logic                    s2_valid,
    input  logic                    s2_clr,
    input  logic signed [P_W-1:0]   s2_prod,
    output logic signed [ACC_W-1:0] acc_q,
    output logic                    out_valid
);

    localparam int unsigned EXT_W = (ACC_W > P_W) ? (ACC_W - P_W) : 1;

    logic signed [ACC_W-1:0] prod_ext;
    logic signed [ACC_W-1:0] feedback;
    logic signed [ACC_W-1:0] sum_n;
    logic                    fold;

    generate
        if (ACC_W > P_W) begin : g_sign_extend
            assign prod_ext = {{EXT_W{s2_prod[P_W-1]}}, s2_prod};
        end else begin : g_same_width
            assign prod_ext = s2_prod;
        end
    endgenerate

    always_comb begin
        fold     = adv && s2_valid;
        feedback = s2_clr ? '0 : acc_q;
        sum_n    = feedback + prod_ext;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q     <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= fold;
            if (fold)
                acc_q <= sum_n;
        end
    end

    // R5
    restart_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && s2_valid && s2_clr) |=> (acc_q == $past(prod_ext)));

    // R9
    wrapping_add_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && s2_valid && !s2_clr) |=> (acc_q == ACC_W'($past(acc_q) + $past(prod_ext))));

    // R6
    bubble_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !adv |=> (!out_valid && $stable(acc_q)));

    // R7
    empty_slot_no_change_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !s2_valid) |=> (!out_valid && $stable(acc_q)));

    // R10
    valid_marks_fold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(s2_valid));

endmodule

// File: rtl/mac_chain_pipe.sv
`timescale 1ns/1ps
module mac_chain_pipe
    import mac_chain_pkg::*;
#(
    parameter int unsigned A_W   = DEF_A_W,
    parameter int unsigned B_W   = DEF_B_W,
    parameter int unsigned ACC_W = DEF_ACC_W,
    localparam int unsigned P_W  = A_W + B_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic                    in_clear,
    input  logic signed [A_W-1:0]   in_a,
    input  logic signed [B_W-1:0]   in_b,
    input  logic                    drain,
    output logic signed [ACC_W-1:0] result,
    output logic                    out_valid
);

    logic                  adv;
    logic                  s1_valid;
    logic                  s1_clr;
    logic signed [A_W-1:0] s1_a;
    logic signed [B_W-1:0] s1_b;
    logic                  s2_valid;
    logic                  s2_clr;
    logic signed [P_W-1:0] s2_prod;

    mac_issue_stage #(.A_W(A_W), .B_W(B_W)) u_issue (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_clear (in_clear),
        .in_a     (in_a),
        .in_b     (in_b),
        .drain    (drain),
        .adv      (adv),
        .s1_valid (s1_valid),
        .s1_clr   (s1_clr),
        .s1_a     (s1_a),
        .s1_b     (s1_b)
    );

    mac_mult_stage #(.A_W(A_W), .B_W(B_W)) u_mult (
        .clk      (clk),
        .rst      (rst),
        .adv      (adv),
        .s1_valid (s1_valid),
        .s1_clr   (s1_clr),
        .s1_a     (s1_a),
        .s1_b     (s1_b),
        .s2_valid (s2_valid),
        .s2_clr   (s2_clr),
        .s2_prod  (s2_prod)
    );

    mac_accum_stage #(.P_W(P_W), .ACC_W(ACC_W)) u_accum (
        .clk       (clk),
        .rst       (rst),
        .adv       (adv),
        .s2_valid  (s2_valid),
        .s2_clr    (s2_clr),
        .s2_prod   (s2_prod),
        .acc_q     (result),
        .out_valid (out_valid)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (result == '0 && !out_valid));

    // R3
    full_pipe_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid ##1 in_valid ##1 in_valid) |=> out_valid);

endmodule

// File: tb/mac_chain_pipe_tb.sv
`timescale 1ns/1ps
module mac_chain_pipe_tb;

    localparam int A_W   = 8;
    localparam int B_W   = 8;
    localparam int ACC_W = 20;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    in_valid = 1'b0;
    logic                    in_clear = 1'b0;
    logic signed [A_W-1:0]   in_a = '0;
    logic signed [B_W-1:0]   in_b = '0;
    logic                    drain = 1'b0;
    logic signed [ACC_W-1:0] result;
    logic                    out_valid;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    mac_chain_pipe #(.A_W(A_W), .B_W(B_W), .ACC_W(ACC_W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_clear  (in_clear),
        .in_a      (in_a),
        .in_b      (in_b),
        .drain     (drain),
        .result    (result),
        .out_valid (out_valid)
    );

    function automatic logic signed [ACC_W-1:0] wrap(input longint v);
        return ACC_W'(v);
    endfunction

    task automatic check(input string req, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Drive one slot, let one edge pass, return 1 ns after it
    task automatic slot(input logic v, input logic d, input logic c, input int a, input int b);
        in_valid = v;
        drain    = d;
        in_clear = c;
        in_a     = A_W'(a);
        in_b     = B_W'(b);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        drain    = 1'b0;
        in_clear = 1'b0;
    endtask

    task automatic test_reset();
        check("R1 result", result, 0);
        check("R1 out_valid", out_valid, 0);
    endtask

    task automatic test_stream();
        longint sums[8];
        longint run = 0;
        for (int j = 0; j < 8; j++) begin
            run += (j + 1) * (2 * j - 3);
            sums[j] = run;
        end
        for (int j = 0; j < 8; j++) begin
            slot(1, 0, j == 0, j + 1, 2 * j - 3);
            check("R2 out_valid", out_valid, (j >= 2) ? 1 : 0);
            if (j >= 2) check("R3 R4 partial", result, wrap(sums[j-2]));
        end
        slot(0, 1, 0, 0, 0);
        check("R7 drain1 valid", out_valid, 1);
        check("R7 drain1 sum", result, wrap(sums[6]));
        slot(0, 1, 0, 0, 0);
        check("R7 drain2 sum", result, wrap(sums[7]));
        slot(0, 1, 0, 0, 0);
        check("R10 drain3 valid", out_valid, 0);
        check("R7 drain3 stable", result, wrap(sums[7]));
    endtask

    task automatic test_clear();
        slot(1, 0, 1, 5, -7);
        slot(1, 0, 0, 3, 3);
        slot(0, 1, 0, 0, 0);
        check("R5 restart", result, -35);
        slot(0, 1, 0, 0, 0);
        check("R5 after restart", result, -26);
    endtask

    task automatic test_bubble();
        slot(1, 0, 1, 6, 7);
        for (int k = 0; k < 3; k++) begin
            slot(0, 0, 0, 0, 0);
            check("R6 bubble valid", out_valid, 0);
            check("R6 bubble result", result, -26);
        end
        slot(1, 0, 0, 2, -5);
        check("R6 no early fold", out_valid, 0);
        slot(0, 1, 0, 0, 0);
        check("R6 first fold", result, 42);
        slot(0, 1, 0, 0, 0);
        check("R6 second fold", result, 32);
        check("R10 second valid", out_valid, 1);
    endtask

    task automatic test_drain_idle();
        for (int k = 0; k < 4; k++) begin
            slot(0, 1, 0, 0, 0);
            check("R7 idle drain valid", out_valid, 0);
            check("R7 idle drain result", result, 32);
        end
    endtask

    task automatic test_priority();
        slot(1, 1, 1, 4, 4);
        slot(0, 1, 0, 0, 0);
        slot(0, 1, 0, 0, 0);
        check("R8 data wins", result, 16);
        check("R8 valid", out_valid, 1);
    endtask

    task automatic test_wrap();
        for (int k = 0; k < 33; k++) slot(1, 0, k == 0, -128, -128);
        slot(0, 1, 0, 0, 0);
        slot(0, 1, 0, 0, 0);
        check("R9 wrap", result, wrap(33 * 16384));
        check("R9 wrap sign", result < 0, 1);
        slot(1, 0, 1, -128, 127);
        slot(0, 1, 0, 0, 0);
        slot(0, 1, 0, 0, 0);
        check("R9 extreme product", result, -16256);
    endtask

    task automatic test_random_padded();
        for (int v = 0; v < 4; v++) begin
            longint refsum = 0;
            int len = 6 + v;
            for (int k = 0; k < len + 3; k++) begin
                int a = 0;
                int b = 0;
                if (k < len) begin
                    a = $urandom_range(255) - 128;
                    b = $urandom_range(255) - 128;
                end
                refsum += a * b;
                slot(1, 0, k == 0, a, b);
            end
            slot(0, 1, 0, 0, 0);
            slot(0, 1, 0, 0, 0);
            check("R4 random dot", result, wrap(refsum));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 in reset", result, 0);
        rst = 1'b0;
        @(posedge clk);
        #1;
        test_reset();
        test_stream();
        test_clear();
        test_bubble();
        test_drain_idle();
        test_priority();
        test_wrap();
        test_random_padded();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule